// File: doc/BRIEF.md
# Snooping Set-Associative Data Cache

This block is the data-side cache of a 32-bit processor. It takes load and store requests whose addresses are already physical and looks each one up in a four-way set-associative store of 8 KB: 128 sets, four ways per set, and 16-byte lines of four 32-bit words. A load that hits is answered from the cache one cycle after it is accepted. A store that hits updates the cached word. Each page is marked either copy-back or write-through. A copy-back store hit only marks the line modified. A write-through store updates the cache when it hits and is then always sent to memory as a bus write.

A load miss, or a copy-back store miss, claims a victim way. If that victim holds modified copy-back data, its four words are written back first. The cache then reads the new line from memory as four single-word transfers in ascending order. A write-through store miss goes to memory only and does not allocate a line.

When another master owns the memory bus, the system presents that master's addresses on the snoop port. A snooped address that matches a valid line invalidates that line. The cache never sends or takes data for such a cycle.

Top module: `snoop_dcache`

## Requirements
- R1: After reset the cache holds no valid line, `req_ready` is 1, and `bus_req` and `resp_valid` are 0.
- R2: The address is split as tag = bits [31:11], set = bits [10:4] and word = bits [3:2]. Bits [1:0] do not affect lookup, so a load of 0x10B returns the same word as a load of 0x108.
- R3: A load that hits raises `resp_valid` with the cached word in the cycle after it is accepted, and issues no bus request.
- R4: A load miss issues four bus reads at line base +0, +4, +8 and +12, in that order. `resp_valid` then returns the requested word, and the line becomes valid.
- R5: A store hit with `req_wt`=0 updates the word and marks the line modified. It issues no bus transfer and responds in the next cycle.
- R6: A store hit with `req_wt`=1 updates the cached word and then issues one bus write of `req_wdata` at `req_addr`. It responds in the cycle after that write's `bus_ack`.
- R7: A store miss with `req_wt`=1 issues exactly one bus write, performs no bus read and allocates no line.
- R8: A store miss with `req_wt`=0 fills the line (four reads), merges the store word into it and marks the line modified.
- R9: Victim choice picks the lowest-numbered invalid way of the set. If every way is valid, it picks a per-set round-robin pointer. The pointer starts at way 0 after reset and moves to one past each way that receives a fill.
- R10: A victim that is valid and modified is written back as four bus writes at its own line address, ascending, before the first fill read.
- R11: A `snoop_valid` cycle whose address matches a valid line invalidates that line, so the next access to it misses. The cycle causes no bus transfer and no response, and lines that do not match stay valid.
- R12: A snoop in the same cycle as a fill completion or a store-hit update of the same line leaves that line invalid, and its modified mark cleared.
- R13: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable from the cycle a request is raised until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Page policy: 1 = write-through, 0 = copy-back |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Cache idle; a request is accepted this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with resp_valid |
| bus_req | output | 1 | Single-word bus transfer requested |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer done; read data valid |
| bus_rdata | input | 32 | Read data |
| snoop_valid | input | 1 | Alternate-master address present |
| snoop_addr | input | 32 | Alternate-master address |

## Verification
Corrupt tag or valid state appears at the ports on the next access to the affected set. A line that should hit instead shows four fill reads, or a snooped line keeps answering with no bus traffic. Both can be seen within a single request. Wrong modified or round-robin state only appears later, at the next eviction from that set: as missing or extra write-back cycles, or as a hit on a line that should have been the one replaced. The table therefore drives sets to full occupancy, and the directed tests evict and re-read specific lines.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_EVICT,
        S_FILL,
        S_THRU
    } dc_state_e;
endpackage

// File: rtl/dcache_victim.sv
module dcache_victim #(
    parameter int WAYS = 4,
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] set_valid,
    input  logic [WAYW-1:0] rr_ptr,
    output logic [WAYW-1:0] victim
);
    logic found;

    always_comb begin
        victim = rr_ptr;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!set_valid[w] && !found) begin
                victim = WAYW'(w);
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        if (!(&set_valid)) begin
            assert_pick_invalid_R9: assert (!set_valid[victim]);
        end
    end
endmodule

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    parameter int TAGW = 21,
    localparam int IDXW = $clog2(SETS),
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDXW-1:0]            lk_idx,
    input  logic [TAGW-1:0]            lk_tag,
    output logic                       lk_hit,
    output logic [WAYW-1:0]            lk_way,
    output logic [WAYS-1:0]            set_valid,
    output logic [WAYS-1:0]            set_dirty,
    output logic [WAYS-1:0][TAGW-1:0]  set_tag,
    output logic [WAYW-1:0]            rr_ptr,
    input  logic                       wr_en,
    input  logic [WAYW-1:0]            wr_way,
    input  logic                       wr_valid,
    input  logic                       wr_dirty,
    input  logic                       wr_alloc,
    input  logic                       sn_en,
    input  logic [IDXW-1:0]            sn_idx,
    input  logic [TAGW-1:0]            sn_tag
);
    logic [TAGW-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    logic [WAYW-1:0] rr_q    [SETS];

    logic [WAYS-1:0] lk_match;
    logic [WAYS-1:0] sn_match;
    logic            sn_same_line;

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            set_tag[w]  = tag_q[lk_idx][w];
            lk_match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
            sn_match[w] = valid_q[sn_idx][w] && (tag_q[sn_idx][w] == sn_tag);
            if (lk_match[w]) lk_way = WAYW'(w);
        end
        lk_hit    = |lk_match;
        set_valid = valid_q[lk_idx];
        set_dirty = dirty_q[lk_idx];
        rr_ptr    = rr_q[lk_idx];
        sn_same_line = sn_en && (sn_idx == lk_idx) && (sn_tag == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            if (sn_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (sn_match[w]) begin
                        valid_q[sn_idx][w] <= 1'b0;
                        dirty_q[sn_idx][w] <= 1'b0;
                    end
                end
            end
            if (wr_en) begin
                tag_q[lk_idx][wr_way]   <= lk_tag;
                valid_q[lk_idx][wr_way] <= wr_valid && !sn_same_line;
                dirty_q[lk_idx][wr_way] <= wr_dirty && !sn_same_line;
                if (wr_alloc) rr_q[lk_idx] <= wr_way + 1'b1;
            end
        end
    end

    assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    for (genvar g = 0; g < WAYS; g++) begin : g_snoop_chk
        assert_snoop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
            sn_en && sn_match[g] && !(wr_en && wr_way == g && sn_idx == lk_idx)
            |=> !valid_q[$past(sn_idx)][g]);
    end

    assert_snoop_beats_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sn_same_line |=> !valid_q[$past(lk_idx)][$past(wr_way)]);
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IDXW  = $clog2(SETS),
    localparam int WAYW  = $clog2(WAYS),
    localparam int WSELW = $clog2(WORDS),
    localparam int DEPTH = SETS * WAYS * WORDS
) (
    input  logic             clk,
    input  logic [IDXW-1:0]  idx,
    input  logic [WAYW-1:0]  rd_way,
    input  logic [WSELW-1:0] rd_word,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [WAYW-1:0]  wr_way,
    input  logic [WSELW-1:0] wr_word,
    input  logic [DW-1:0]    wr_data
);
    logic [DW-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[{idx, rd_way, rd_word}];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{idx, wr_way, wr_word}] <= wr_data;
    end
endmodule

// File: rtl/snoop_dcache.sv
module snoop_dcache
    import dcache_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_wt,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr
);
    localparam int BOFF  = $clog2(DW / 8);
    localparam int WSELW = $clog2(WORDS);
    localparam int OFFW  = BOFF + WSELW;
    localparam int IDXW  = $clog2(SETS);
    localparam int TAGW  = AW - IDXW - OFFW;
    localparam int WAYW  = $clog2(WAYS);
    localparam logic [WSELW-1:0] LAST = WSELW'(WORDS - 1);

    typedef struct packed {
        dc_state_e        st;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             we;
        logic [WAYW-1:0]  way;
        logic [WSELW-1:0] cnt;
        logic [TAGW-1:0]  vtag;
        logic [DW-1:0]    rdata;
        logic             resp;
    } ctrl_t;

    ctrl_t q, n;

    logic [TAGW-1:0]  lk_tag;
    logic [IDXW-1:0]  lk_idx;
    logic [WSELW-1:0] lk_word;
    logic             lk_hit;
    logic [WAYW-1:0]  lk_way;
    logic [WAYS-1:0]  set_valid, set_dirty;
    logic [WAYS-1:0][TAGW-1:0] set_tag;
    logic [WAYW-1:0]  rr_ptr, victim;

    logic             tw_en, tw_valid, tw_dirty, tw_alloc;
    logic [WAYW-1:0]  tw_way;
    logic             dw_en;
    logic [WAYW-1:0]  dw_way, rd_way;
    logic [WSELW-1:0] dw_word, rd_word;
    logic [DW-1:0]    dw_data, rd_data;
    logic             unused_snoop_offset;

    assign unused_snoop_offset = ^snoop_addr[OFFW-1:0];

    assign lk_tag  = (q.st == S_IDLE) ? req_addr[AW-1 -: TAGW]  : q.addr[AW-1 -: TAGW];
    assign lk_idx  = (q.st == S_IDLE) ? req_addr[OFFW +: IDXW]  : q.addr[OFFW +: IDXW];
    assign lk_word = (q.st == S_IDLE) ? req_addr[BOFF +: WSELW] : q.addr[BOFF +: WSELW];
    assign rd_way  = (q.st == S_EVICT) ? q.way : lk_way;
    assign rd_word = (q.st == S_EVICT) ? q.cnt : lk_word;

    dcache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAGW(TAGW)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .set_valid (set_valid),
        .set_dirty (set_dirty),
        .set_tag   (set_tag),
        .rr_ptr    (rr_ptr),
        .wr_en     (tw_en),
        .wr_way    (tw_way),
        .wr_valid  (tw_valid),
        .wr_dirty  (tw_dirty),
        .wr_alloc  (tw_alloc),
        .sn_en     (snoop_valid),
        .sn_idx    (snoop_addr[OFFW +: IDXW]),
        .sn_tag    (snoop_addr[AW-1 -: TAGW])
    );

    dcache_victim #(.WAYS(WAYS)) u_victim (
        .set_valid (set_valid),
        .rr_ptr    (rr_ptr),
        .victim    (victim)
    );

    dcache_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DW(DW)) u_data (
        .clk     (clk),
        .idx     (lk_idx),
        .rd_way  (rd_way),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .wr_en   (dw_en),
        .wr_way  (dw_way),
        .wr_word (dw_word),
        .wr_data (dw_data)
    );

    always_comb begin
        n         = q;
        n.resp    = 1'b0;
        tw_en     = 1'b0;
        tw_way    = q.way;
        tw_valid  = 1'b0;
        tw_dirty  = 1'b0;
        tw_alloc  = 1'b0;
        dw_en     = 1'b0;
        dw_way    = q.way;
        dw_word   = q.cnt;
        dw_data   = bus_rdata;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    n.addr  = req_addr;
                    n.wdata = req_wdata;
                    n.we    = req_write;
                    n.rdata = '0;
                    if (lk_hit) begin
                        if (!req_write) begin
                            n.resp  = 1'b1;
                            n.rdata = rd_data;
                        end else begin
                            dw_en   = 1'b1;
                            dw_way  = lk_way;
                            dw_word = lk_word;
                            dw_data = req_wdata;
                            if (req_wt) begin
                                n.st = S_THRU;
                            end else begin
                                tw_en    = 1'b1;
                                tw_way   = lk_way;
                                tw_valid = 1'b1;
                                tw_dirty = 1'b1;
                                n.resp   = 1'b1;
                            end
                        end
                    end else if (req_write && req_wt) begin
                        n.st = S_THRU;
                    end else begin
                        n.way  = victim;
                        n.cnt  = '0;
                        n.vtag = set_tag[victim];
                        if (set_valid[victim] && set_dirty[victim]) begin
                            n.st = S_EVICT;
                        end else begin
                            n.st   = S_FILL;
                            tw_en  = 1'b1;
                            tw_way = victim;
                        end
                    end
                end
            end
            S_EVICT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = {q.vtag, lk_idx, q.cnt, {BOFF{1'b0}}};
                bus_wdata = rd_data;
                if (bus_ack) begin
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        n.st  = S_FILL;
                        tw_en = 1'b1;
                    end
                end
            end
            S_FILL: begin
                bus_req  = 1'b1;
                bus_addr = {lk_tag, lk_idx, q.cnt, {BOFF{1'b0}}};
                if (bus_ack) begin
                    dw_en = 1'b1;
                    if (q.cnt == lk_word) begin
                        if (q.we) dw_data = q.wdata;
                        else      n.rdata = bus_rdata;
                    end
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        tw_en    = 1'b1;
                        tw_valid = 1'b1;
                        tw_dirty = q.we;
                        tw_alloc = 1'b1;
                        n.st     = S_IDLE;
                        n.resp   = 1'b1;
                    end
                end
            end
            S_THRU: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = q.addr;
                bus_wdata = q.wdata;
                if (bus_ack) begin
                    n.st   = S_IDLE;
                    n.resp = 1'b1;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign resp_valid = q.resp;
    assign resp_rdata = q.rdata;

    assert_bus_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    assert_load_hit_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write && lk_hit |=> resp_valid && !bus_req);

    assert_cb_hit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write && !req_wt && lk_hit |=> resp_valid && !bus_req);

    assert_thru_miss_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write && req_wt && !lk_hit |=> bus_req && bus_we);

    assert_evict_then_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == S_EVICT && bus_ack && q.cnt == LAST |=> bus_req && !bus_we);
endmodule

// File: tb/snoop_dcache_bench.sv
module snoop_dcache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid, bus_req, bus_we;
    logic [31:0] resp_rdata, bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        tb_sn_v = 1'b0, mem_sn_v = 1'b0, snoop_valid;
    logic [31:0] tb_sn_a = '0, mem_sn_a = '0, snoop_addr;
    logic        arm_fill_snoop = 1'b0;

    assign snoop_valid = tb_sn_v | mem_sn_v;
    assign snoop_addr  = mem_sn_v ? mem_sn_a : tb_sn_a;

    always #10 clk = ~clk;

    snoop_dcache u_snoop_dcache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wt(req_wt),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [4096];
    logic [31:0] log_addr [512];
    logic        log_we [512];
    int          log_n = 0;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            mem_sn_v <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) mem[bus_addr[13:2]] = bus_wdata;
            else        bus_rdata <= mem[bus_addr[13:2]];
            log_addr[log_n % 512] = bus_addr;
            log_we[log_n % 512]   = bus_we;
            log_n = log_n + 1;
            mem_sn_v <= arm_fill_snoop && !bus_we && (bus_addr[3:2] == 2'd3);
            mem_sn_a <= bus_addr;
        end else begin
            bus_ack  <= 1'b0;
            mem_sn_v <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic we, input logic wt, input logic [31:0] a, input logic [31:0] wd,
                          input logic snoop_same, output logic [31:0] rd, output int lat,
                          output int nrd, output int nwr, output int base);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 400) begin @(negedge clk); guard++; end
        base = log_n;
        req_valid = 1'b1; req_write = we; req_wt = wt; req_addr = a; req_wdata = wd;
        if (snoop_same) begin tb_sn_v = 1'b1; tb_sn_a = a; end
        @(negedge clk);
        req_valid = 1'b0; tb_sn_v = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 400) begin @(negedge clk); lat++; end
        if (!resp_valid) check(1'b0, "timeout", 32'(lat), 32'd400);
        rd = resp_rdata;
        nrd = 0; nwr = 0;
        for (int k = base; k < log_n; k++) begin
            if (log_we[k % 512]) nwr++; else nrd++;
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        wt;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
        logic [31:0] vbase;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 32'h0104, 32'h0,         32'hC0DE0041, 4'd4, 4'd0, 32'h0,    8'd4},  // R4 first miss, R1
        '{1'b0, 1'b0, 32'h0108, 32'h0,         32'hC0DE0042, 4'd0, 4'd0, 32'h0,    8'd3},  // R3
        '{1'b0, 1'b0, 32'h010B, 32'h0,         32'hC0DE0042, 4'd0, 4'd0, 32'h0,    8'd2},  // R2
        '{1'b1, 1'b0, 32'h010C, 32'h11112222,  32'h0,        4'd0, 4'd0, 32'h0,    8'd5},  // R5
        '{1'b0, 1'b0, 32'h010C, 32'h0,         32'h11112222, 4'd0, 4'd0, 32'h0,    8'd5},  // R5
        '{1'b1, 1'b1, 32'h0100, 32'h33334444,  32'h0,        4'd0, 4'd1, 32'h0,    8'd6},  // R6
        '{1'b0, 1'b0, 32'h0100, 32'h0,         32'h33334444, 4'd0, 4'd0, 32'h0,    8'd6},  // R6
        '{1'b1, 1'b1, 32'h2200, 32'h55556666,  32'h0,        4'd0, 4'd1, 32'h0,    8'd7},  // R7
        '{1'b0, 1'b0, 32'h2200, 32'h0,         32'h55556666, 4'd4, 4'd0, 32'h0,    8'd7},  // R7 no allocate
        '{1'b1, 1'b0, 32'h0A34, 32'h77778888,  32'h0,        4'd4, 4'd0, 32'h0,    8'd8},  // R8
        '{1'b0, 1'b0, 32'h0A30, 32'h0,         32'hC0DE028C, 4'd0, 4'd0, 32'h0,    8'd8},  // R8
        '{1'b0, 1'b0, 32'h0A34, 32'h0,         32'h77778888, 4'd0, 4'd0, 32'h0,    8'd8},  // R8 merged
        '{1'b0, 1'b0, 32'h0900, 32'h0,         32'hC0DE0240, 4'd4, 4'd0, 32'h0,    8'd9},  // R9 way1
        '{1'b0, 1'b0, 32'h1100, 32'h0,         32'hC0DE0440, 4'd4, 4'd0, 32'h0,    8'd9},  // R9 way2
        '{1'b0, 1'b0, 32'h1900, 32'h0,         32'hC0DE0640, 4'd4, 4'd0, 32'h0,    8'd9},  // R9 way3
        '{1'b0, 1'b0, 32'h2100, 32'h0,         32'hC0DE0840, 4'd4, 4'd4, 32'h0100, 8'd10}, // R10 dirty way0
        '{1'b0, 1'b0, 32'h010C, 32'h0,         32'h11112222, 4'd4, 4'd0, 32'h0,    8'd10}, // R10 written back
        '{1'b0, 1'b0, 32'h0900, 32'h0,         32'hC0DE0240, 4'd4, 4'd0, 32'h0,    8'd9},  // R9 way1 was evicted
        '{1'b0, 1'b0, 32'h1900, 32'h0,         32'hC0DE0640, 4'd0, 4'd0, 32'h0,    8'd9},  // R9 way3 kept
        '{1'b0, 1'b0, 32'h1100, 32'h0,         32'hC0DE0440, 4'd4, 4'd0, 32'h0,    8'd9},  // R9
        '{1'b0, 1'b0, 32'h2100, 32'h0,         32'hC0DE0840, 4'd0, 4'd0, 32'h0,    8'd9}   // R9 way0 kept
    };

    task automatic show_summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", 32'(cycles), 32'd100000);
            show_summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int lat, nrd, nwr, base;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1,  "R1 req_ready",  32'(req_ready),  32'd1);
        check(bus_req == 1'b0,    "R1 bus_req",    32'(bus_req),    32'd0);
        check(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 32'd0);

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
            run_op(VEC[v].we, VEC[v].wt, VEC[v].addr, VEC[v].wdata, 1'b0, rd, lat, nrd, nwr, base);
            if (!VEC[v].we) check(rd == VEC[v].exp, {tag, " data"}, rd, VEC[v].exp);
            check(nrd == int'(VEC[v].nrd), {tag, " reads"}, 32'(nrd), 32'(VEC[v].nrd));
            check(nwr == int'(VEC[v].nwr), {tag, " writes"}, 32'(nwr), 32'(VEC[v].nwr));
            if (nrd == 0 && nwr == 0 && VEC[v].nrd == 0 && VEC[v].nwr == 0)
                check(lat == 1, {tag, " R3 hit latency"}, 32'(lat), 32'd1);
            if (VEC[v].nwr == 4 && nwr == 4) begin
                for (int k = 0; k < 4; k++)  // R10 write-back order
                    check(log_we[(base + k) % 512] && log_addr[(base + k) % 512] == VEC[v].vbase + 32'(4 * k),
                          {tag, " R10 wb addr"}, log_addr[(base + k) % 512], VEC[v].vbase + 32'(4 * k));
            end
            if (VEC[v].nrd == 4 && nrd == 4) begin
                for (int k = 0; k < 4; k++)  // R4 ascending fill
                    check(!log_we[(base + nwr + k) % 512] &&
                          log_addr[(base + nwr + k) % 512] == {VEC[v].addr[31:4], 4'h0} + 32'(4 * k),
                          {tag, " R4 fill addr"}, log_addr[(base + nwr + k) % 512],
                          {VEC[v].addr[31:4], 4'h0} + 32'(4 * k));
            end
            if (VEC[v].wt && VEC[v].we && nwr == 1)  // R6 / R7 write content
                check(mem[VEC[v].addr[13:2]] == VEC[v].wdata, {tag, " memory"}, mem[VEC[v].addr[13:2]], VEC[v].wdata);
        end

        // R11: snoop of 0x900 (valid, set 0x10) invalidates only that line
        @(negedge clk);
        tb_sn_v = 1'b1; tb_sn_a = 32'h0900;
        @(negedge clk);
        tb_sn_v = 1'b0;
        check(bus_req == 1'b0,    "R11 snoop no bus",  32'(bus_req),    32'd0);
        check(resp_valid == 1'b0, "R11 snoop no resp", 32'(resp_valid), 32'd0);
        run_op(1'b0, 1'b0, 32'h1100, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        check(nrd == 0 && rd == 32'hC0DE0440, "R11 neighbour still hits", rd, 32'hC0DE0440);
        run_op(1'b0, 1'b0, 32'h0900, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        check(nrd == 4, "R11 snooped line misses", 32'(nrd), 32'd4);
        check(rd == 32'hC0DE0240, "R11 refill data", rd, 32'hC0DE0240);
        // R9: the invalid way was refilled, not the round-robin way 0
        run_op(1'b0, 1'b0, 32'h2100, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        check(nrd == 0 && rd == 32'hC0DE0840, "R9 invalid way chosen first", 32'(nrd), 32'd0);

        // R12: snoop on the final fill beat of the same line
        arm_fill_snoop = 1'b1;
        run_op(1'b0, 1'b0, 32'h3100, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        arm_fill_snoop = 1'b0;
        check(rd == 32'hC0DE0C40, "R12 fill data returned", rd, 32'hC0DE0C40);
        run_op(1'b0, 1'b0, 32'h3100, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        check(nrd == 4, "R12 fill-time snoop leaves line invalid", 32'(nrd), 32'd4);

        // R12: snoop in the same cycle as a copy-back store hit
        run_op(1'b1, 1'b0, 32'h3104, 32'h99990000, 1'b1, rd, lat, nrd, nwr, base);
        check(nrd == 0 && nwr == 0, "R12 store hit quiet", 32'(nrd + nwr), 32'd0);
        run_op(1'b0, 1'b0, 32'h3104, 32'h0, 1'b0, rd, lat, nrd, nwr, base);
        check(nrd == 4, "R12 store-time snoop leaves line invalid", 32'(nrd), 32'd4);
        check(nwr == 0, "R12 modified mark cleared", 32'(nwr), 32'd0);
        check(rd == 32'hC0DE0C41, "R12 memory data", rd, 32'hC0DE0C41);

        show_summary();
        $finish;
    end
endmodule